// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This unit is the arithmetic and logic stage of a 32-bit load/store integer pipeline. Each cycle it can accept one operation, given as the raw 6-bit primary opcode and 6-bit function code together with two register operand values, a 16-bit immediate and a 5-bit shift count. A small internal table turns the opcode and function code into an operation select and an immediate extension mode. The unit covers register-register add, subtract, OR, XOR and NOR, constant shifts of the second register operand, immediate add, AND and OR, and load-upper-immediate.

The immediate path depends on the operation. Immediate add sign-extends the 16-bit field. Immediate AND and OR zero-extend it. Load-upper places the field in the upper half of the word. Sums and differences wrap modulo 2^32 and never signal overflow. An opcode/function pair that the table does not know gives a zero result and raises an illegal-operation flag.

The result is captured in one register stage. An accepted operation appears on the outputs one clock later, together with a zero flag for comparisons.

Top module: `ex_alu_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `result`=0, `zero`=0 and `illegal`=0.
- R2: An operation accepted with `in_valid`=1 at a rising edge produces `out_valid`=1 after that edge. After an edge with `in_valid`=0, `out_valid` is 0.
- R3: With opcode 0x00, function 0x21 gives `rs_val + rt_val` and function 0x23 gives `rs_val - rt_val`. Both wrap modulo 2^32.
- R4: With opcode 0x00, function 0x25 gives `rs_val | rt_val`, 0x26 gives `rs_val ^ rt_val` and 0x27 gives `~(rs_val | rt_val)`.
- R5: With opcode 0x00, the shifts act on `rt_val` by `shamt`. Function 0x00 shifts left, 0x02 shifts right filling with zeros, and 0x03 shifts right copying bit 31.
- R6: Opcode 0x09 gives `rs_val` plus the immediate sign-extended from bit 15, wrapping modulo 2^32.
- R7: Opcode 0x0C gives `rs_val` AND the zero-extended immediate. Opcode 0x0D gives `rs_val` OR the zero-extended immediate.
- R8: Opcode 0x0F gives the immediate in bits 31:16 with bits 15:0 zero, whatever the register operands hold.
- R9: Any other opcode, or opcode 0x00 with any other function code, gives `result`=0 and `illegal`=1. Every listed operation gives `illegal`=0.
- R10: When `out_valid` is 1, `zero` is 1 exactly when `result` is 0.
- R11: After an edge with `in_valid`=0, `result`, `zero` and `illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code field, used with opcode 0x00 |
| shamt | input | 5 | Constant shift count |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered result equals zero |
| illegal | output | 1 | Registered operation was not recognised |

## Verification
The assertions expect every data input to hold a known value in any cycle where `in_valid` is high. They also expect reset to be asserted at the first clock edge, so the hold and latency properties start from a defined register state. The bench sets every field before it raises `in_valid`. It asserts reset for several cycles before the first operation. It leaves idle gaps between bursts so the hold behaviour is observed with real stale data in the registers.

// File: rtl/ex_alu_pkg.sv
package ex_alu_pkg;

    localparam logic [5:0] OPC_REGOP = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h09;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_UPPER = 6'h0F;

    localparam logic [5:0] FN_SHL    = 6'h00;
    localparam logic [5:0] FN_SHR    = 6'h02;
    localparam logic [5:0] FN_SHRA   = 6'h03;
    localparam logic [5:0] FN_ADD    = 6'h21;
    localparam logic [5:0] FN_SUB    = 6'h23;
    localparam logic [5:0] FN_OR     = 6'h25;
    localparam logic [5:0] FN_XOR    = 6'h26;
    localparam logic [5:0] FN_NOR    = 6'h27;

    typedef enum logic [3:0] {
        SEL_ADD,
        SEL_SUB,
        SEL_OR,
        SEL_XOR,
        SEL_NOR,
        SEL_AND,
        SEL_SHL,
        SEL_SHR,
        SEL_SHRA,
        SEL_PASSB,
        SEL_NONE
    } alu_sel_e;

    typedef enum logic [1:0] {
        EXT_SIGN,
        EXT_ZERO,
        EXT_UPPER
    } ext_mode_e;

    typedef struct packed {
        alu_sel_e  sel;
        logic      use_imm;
        ext_mode_e ext;
        logic      illegal;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [5:0] opc, input logic [5:0] fn);
        alu_ctrl_t c;
        c.sel     = SEL_NONE;
        c.use_imm = 1'b0;
        c.ext     = EXT_ZERO;
        c.illegal = 1'b0;
        unique case (opc)
            OPC_REGOP: begin
                unique case (fn)
                    FN_ADD:  c.sel = SEL_ADD;
                    FN_SUB:  c.sel = SEL_SUB;
                    FN_OR:   c.sel = SEL_OR;
                    FN_XOR:  c.sel = SEL_XOR;
                    FN_NOR:  c.sel = SEL_NOR;
                    FN_SHL:  c.sel = SEL_SHL;
                    FN_SHR:  c.sel = SEL_SHR;
                    FN_SHRA: c.sel = SEL_SHRA;
                    default: c.illegal = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                c.sel = SEL_ADD; c.use_imm = 1'b1; c.ext = EXT_SIGN;
            end
            OPC_ANDI: begin
                c.sel = SEL_AND; c.use_imm = 1'b1; c.ext = EXT_ZERO;
            end
            OPC_ORI: begin
                c.sel = SEL_OR; c.use_imm = 1'b1; c.ext = EXT_ZERO;
            end
            OPC_UPPER: begin
                c.sel = SEL_PASSB; c.use_imm = 1'b1; c.ext = EXT_UPPER;
            end
            default: c.illegal = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import ex_alu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output alu_ctrl_t  ctrl
);
    always_comb ctrl = decode_op(opcode, funct);
endmodule

// File: rtl/alu_imm_extend.sv
module alu_imm_extend
    import ex_alu_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    input  ext_mode_e        mode,
    output logic [XLEN-1:0]  imm_ext
);
    localparam int unsigned PAD_W = XLEN - IMM_W;

    always_comb begin
        unique case (mode)
            EXT_SIGN:  imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
            EXT_UPPER: imm_ext = {imm, {PAD_W{1'b0}}};
            default:   imm_ext = {{PAD_W{1'b0}}, imm};
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import ex_alu_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned SHAMT_W = 5
) (
    input  logic [XLEN-1:0]    opa,
    input  logic [XLEN-1:0]    opb,
    input  logic [SHAMT_W-1:0] shamt,
    input  alu_sel_e           sel,
    output logic [XLEN-1:0]    y
);
    always_comb begin
        unique case (sel)
            SEL_ADD:   y = opa + opb;
            SEL_SUB:   y = opa - opb;
            SEL_OR:    y = opa | opb;
            SEL_XOR:   y = opa ^ opb;
            SEL_NOR:   y = ~(opa | opb);
            SEL_AND:   y = opa & opb;
            SEL_SHL:   y = opb << shamt;
            SEL_SHR:   y = opb >> shamt;
            SEL_SHRA:  y = $unsigned($signed(opb) >>> shamt);
            SEL_PASSB: y = opb;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/ex_alu_unit.sv
module ex_alu_unit
    import ex_alu_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned SHAMT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [5:0]         opcode,
    input  logic [5:0]         funct,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [XLEN-1:0]    rs_val,
    input  logic [XLEN-1:0]    rt_val,
    input  logic [IMM_W-1:0]   imm,
    output logic               out_valid,
    output logic [XLEN-1:0]    result,
    output logic               zero,
    output logic               illegal
);
    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] y;

    alu_op_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    alu_imm_extend #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
        .imm     (imm),
        .mode    (ctrl.ext),
        .imm_ext (imm_ext)
    );

    assign opb = ctrl.use_imm ? imm_ext : rt_val;

    alu_core #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_core (
        .opa   (rs_val),
        .opb   (opb),
        .shamt (shamt),
        .sel   (ctrl.sel),
        .y     (y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            zero      <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= y;
                zero    <= (y == '0);
                illegal <= ctrl.illegal;
            end
        end
    end
endmodule

// File: rtl/ex_alu_unit_chk.sv
module ex_alu_unit_chk #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned SHAMT_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [5:0]         opcode,
    input logic [5:0]         funct,
    input logic [SHAMT_W-1:0] shamt,
    input logic [XLEN-1:0]    rs_val,
    input logic [XLEN-1:0]    rt_val,
    input logic [IMM_W-1:0]   imm,
    input logic               out_valid,
    input logic [XLEN-1:0]    result,
    input logic               zero,
    input logic               illegal
);
    logic [XLEN-1:0] sum_in;
    assign sum_in = rs_val + rt_val;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !zero && !illegal));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_add_wraps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 6'h00 && funct == 6'h21) |=> (result == $past(sum_in)));

    a_r8_upper_low_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 6'h0F) |=> (result[IMM_W-1:0] == '0 && !illegal));

    a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (result == '0));

    a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zero == (result == '0)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(zero) && $stable(illegal)));
endmodule

bind ex_alu_unit ex_alu_unit_chk #(
    .XLEN(XLEN), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
) i_chk (.*);

// File: tb/test_ex_alu_unit.sv
`timescale 1ns/1ps
module test_ex_alu_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] res;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ex_alu_unit i_ex_alu_unit (.*);

    function automatic void expect_of(input logic [5:0] op, input logic [5:0] fn,
                                      input logic [31:0] a, input logic [31:0] b,
                                      input logic [15:0] im, input logic [4:0] sh,
                                      output logic [31:0] r, output logic ill);
        logic [31:0] sx, zx;
        sx = {{16{im[15]}}, im};
        zx = {16'h0000, im};
        ill = 1'b0;
        r = 32'h0;
        if (op == 6'h00) begin
            case (fn)
                6'h21: r = a + b;
                6'h23: r = a - b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h27: r = ~(a | b);
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = $unsigned($signed(b) >>> sh);
                default: ill = 1'b1;
            endcase
        end else if (op == 6'h09) r = a + sx;
        else if (op == 6'h0C) r = a & zx;
        else if (op == 6'h0D) r = a | zx;
        else if (op == 6'h0F) r = {im, 16'h0000};
        else ill = 1'b1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        exp_t e;
        @(negedge clk);
        opcode = op; funct = fn; rs_val = a; rt_val = b; imm = im; shamt = sh;
        in_valid = 1'b1;
        expect_of(op, fn, a, b, im, sh, e.res, e.ill);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode = 6'h3F; rs_val = 32'hA5A5_A5A5; rt_val = 32'h5A5A_5A5A; imm = 16'h1234;
        end
    endtask

    logic [31:0] last_res = '0;
    logic        last_zero = 1'b0;
    logic        last_ill = 1'b0;
    logic        seen = 1'b0;

    // Monitor: outputs change only at rising edges, so the falling edge is a safe sample point.
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, result, e.res);
                    check({e.tag, " illegal flag R9"}, {31'd0, illegal}, {31'd0, e.ill});
                    check("R10 zero flag", {31'd0, zero}, {31'd0, (e.res == 32'h0)});
                end
            end else if (seen) begin
                check("R11 result held", result, last_res);
                check("R11 flags held", {30'd0, zero, illegal}, {30'd0, last_zero, last_ill});
            end
            last_res = result; last_zero = zero; last_ill = illegal; seen = 1'b1;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 flags", {30'd0, zero, illegal}, 32'd0);
        @(negedge clk); rst = 1'b0;

        drive("R3 add wrap", 6'h00, 6'h21, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
        drive("R3 add", 6'h00, 6'h21, 32'h1234_0000, 32'h0000_5678, 16'h0, 5'd0);
        drive("R3 sub wrap", 6'h00, 6'h23, 32'h0, 32'h1, 16'h0, 5'd0);
        drive("R3 sub equal", 6'h00, 6'h23, 32'hCAFE_0001, 32'hCAFE_0001, 16'h0, 5'd0);
        drive("R4 or", 6'h00, 6'h25, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 5'd0);
        drive("R4 xor", 6'h00, 6'h26, 32'hFFFF_0000, 32'hFF00_FF00, 16'h0, 5'd0);
        drive("R4 nor", 6'h00, 6'h27, 32'h0F0F_0F0F, 32'h00F0_00F0, 16'h0, 5'd0);
        drive("R4 nor all ones", 6'h00, 6'h27, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 5'd0);
        idle(2);
        drive("R5 shift left 31", 6'h00, 6'h00, 32'hDEAD_BEEF, 32'h0000_0003, 16'h0, 5'd31);
        drive("R5 shift right zero fill", 6'h00, 6'h02, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
        drive("R5 shift right sign fill", 6'h00, 6'h03, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
        drive("R5 sign fill positive", 6'h00, 6'h03, 32'h0, 32'h7000_0000, 16'h0, 5'd28);
        drive("R5 shift by zero", 6'h00, 6'h02, 32'h0, 32'h1357_9BDF, 16'h0, 5'd0);
        drive("R6 add imm negative", 6'h09, 6'h3F, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0);
        drive("R6 add imm min", 6'h09, 6'h00, 32'h0, 32'h0, 16'h8000, 5'd0);
        drive("R6 add imm positive", 6'h09, 6'h00, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0);
        idle(3);
        drive("R7 and imm zero ext", 6'h0C, 6'h00, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);
        drive("R7 or imm zero ext", 6'h0D, 6'h00, 32'h0, 32'h0, 16'hFFFF, 5'd0);
        drive("R7 or imm keeps upper", 6'h0D, 6'h00, 32'hABCD_0000, 32'h0, 16'h8000, 5'd0);
        drive("R8 load upper", 6'h0F, 6'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hDEAD, 5'd7);
        drive("R8 load upper zero", 6'h0F, 6'h21, 32'h1234_5678, 32'h1, 16'h0000, 5'd0);
        drive("R9 bad opcode", 6'h3F, 6'h21, 32'h1, 32'h2, 16'h3, 5'd1);
        drive("R9 bad funct", 6'h00, 6'h01, 32'h1, 32'h2, 16'h3, 5'd1);
        drive("R9 bad opcode 0x08", 6'h08, 6'h00, 32'h10, 32'h20, 16'h30, 5'd0);
        idle(2);
        for (int k = 0; k < 8; k++) begin
            drive("R3 add sweep", 6'h00, 6'h21, 32'h1357_9BDF * (k + 1), 32'hF00D_0000 ^ k, 16'h0, 5'd0);
            drive("R5 left sweep", 6'h00, 6'h00, 32'h0, 32'h8000_0001, 16'h0, 5'(k * 4 + 1));
        end
        idle(4);
        if (sb.size() != 0) check("R2 results outstanding", sb.size(), 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule